// File: doc/BRIEF.md
# Dithered Delta-Sigma Divide-Ratio Modulator

This block runs on the reference clock of a fractional-N frequency synthesizer and, once per reference cycle, hands the feedback divider an integer divide value. The values it emits jump around a programmed integer setting. Their long-run mean equals that setting plus an unsigned binary fraction. The quantization error of the fraction is shaped toward high frequencies, where the loop filter removes it. The shaping comes from three cascaded first-order accumulators. Their carries are combined through difference filters into a small signed correction, so the divider only ever sees the setting plus a value between -3 and +3.

Noise-shaping order is chosen per cycle by an input. An optional pseudo-random bit from a linear feedback shift register can be injected into the lowest fraction bit to break up short repeating patterns. Settings are taken on the same edge that registers the output they produce, so a change never tears an output word. The accumulators are not touched when the setting changes, so the frequency moves without a phase restart.

Top module: `dsm_divmod`

## Requirements
- R1: While `rst_n` is low (asynchronously) or `sync_clr` is high at a clock edge, the block clears all accumulators, difference history and overflow remainder, and reloads the shift register seed. After that edge `div_vld` is 0, `div_val` is 0 and `div_ofs` is 0.
- R2: After any edge with `rst_n` high and `sync_clr` low, `div_vld` is 1, so the first valid word appears one cycle after the clear is released.
- R3: Whenever `div_vld` is 1, `div_ofs` lies in -3..+3. `div_val` equals `int_set` sampled at the same edge plus `div_ofs`, modulo 2^IW, for settings in 3..2^IW-4.
- R4: With dither off, starting from a clear, the sum of `div_ofs` over 4096 cycles is 4096·`frac_set`/2^FW within ±3, in both second and third order.
- R5: `order_sel` = 1 selects first order, where the correction is the stage-1 carry. With `frac_set` = 2^(FW-1), dither off, the output after a clear alternates int, int+1, int, ... starting with int.
- R6: With `frac_set` = 0 and dither off, every valid output equals `int_set` exactly.
- R7: In third order (`order_sel` 0 or 3) with a fraction near 0.01 and dither on, after a 256-cycle settle no run of identical outputs is longer than 32 cycles.
- R8: The dither source is an LFSR of width LW (default 23). It shifts left, and its new bit 0 is the XOR of its top bit with its tap bit (bit 17 for width 23). The seed has only the top bit and bit 0 set. Bit 0 of the state is added to the stage-1 input when `dither_en` is 1, and the register advances every active cycle. With `frac_set` = 2^(FW-1)-1 and order 1, the second output after a clear is int with dither off and int+1 with dither on.
- R9: In each active cycle the stage-1 accumulator adds `frac_set` (+dither bit), and each later stage adds the new residue of the stage before it. The correction is c1, plus (c2 - c2 delayed) in second order, plus (c3 - 2·c3 delayed + c3 delayed twice) in third order. A setting change does not clear any of this state.
- R10: When the correction plus any held remainder exceeds +3, `div_ofs` is +3 and the excess of 1 is added to the next cycle's correction, so the mean is kept exact. A held remainder is never followed by another overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clr | input | 1 | Synchronous clear of all modulator state |
| int_set | input | IW | Integer part of the divide ratio |
| frac_set | input | FW | Unsigned fraction, weight 2^-FW per LSB |
| order_sel | input | 2 | 1 first, 2 second, 0 or 3 third order |
| dither_en | input | 1 | Add LFSR bit to the fraction LSB |
| div_val | output | IW | Divide value for the feedback counter |
| div_ofs | output | 3 | Signed correction applied to int_set |
| div_vld | output | 1 | Output word valid |

## Verification
The two functions that can meet in one cycle are the overflow-remainder payback and a change of the integer or fraction setting. A clear can also coincide with a setting change. A long dithered third-order run toggles the integer setting every 37 cycles and the fraction every 501. Some changes therefore land on cycles where a +4 correction is being clamped or paid back. Every cycle is judged against a behavioural model, and the payback cycle is checked to still add on the new integer.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  localparam int STAGES  = 3;
  localparam int OFS_MAX = 3;

  typedef logic signed [2:0] ofs_t;

  typedef enum logic [1:0] {
    ORD_THIRD_ALT = 2'd0,
    ORD_FIRST     = 2'd1,
    ORD_SECOND    = 2'd2,
    ORD_THIRD     = 2'd3
  } order_e;

  // Second feedback tap (1-based) for maximal-length Fibonacci LFSRs.
  function automatic int lfsr_tap(input int width);
    case (width)
      23:      return 18;
      25:      return 22;
      28:      return 25;
      31:      return 28;
      default: return 18;
    endcase
  endfunction

endpackage

// File: rtl/dsm_lfsr.sv
module dsm_lfsr #(
  parameter int W = 23
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic bit_o
);
  localparam int TAP = dsm_pkg::lfsr_tap(W);
  localparam logic [W-1:0] SEED = {1'b1, {(W-2){1'b0}}, 1'b1};

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         fb;

  always_comb begin
    fb      = state_q[W-1] ^ state_q[TAP-1];
    state_d = state_q;
    if (clr) begin
      state_d = SEED;
    end else if (en) begin
      state_d = {state_q[W-2:0], fb};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else begin
      state_q <= state_d;
    end
  end

  assign bit_o = state_q[0];

  // R8: the register never locks up in the all-zero state
  a_r8_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  // R1: a clear reloads the seed
  a_r1_lfsr_reseed: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (state_q == SEED));

endmodule

// File: rtl/dsm_acc_stage.sv
module dsm_acc_stage #(
  parameter int FW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [FW-1:0] addend,
  input  logic          cin,
  output logic [FW-1:0] resid_o,
  output logic          carry_o
);
  logic [FW-1:0] acc_q;
  logic [FW-1:0] acc_d;
  logic [FW:0]   sum;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, addend} + {{FW{1'b0}}, cin};
    resid_o = sum[FW-1:0];
    carry_o = sum[FW];
    acc_d   = acc_q;
    if (clr) begin
      acc_d = '0;
    end else if (en) begin
      acc_d = sum[FW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  // R1: clear leaves the accumulator empty
  a_r1_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));

  // R9: an idle-free stage only holds its value when nothing is added
  a_r9_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && en && addend == '0 && !cin) |=> $stable(acc_q));

endmodule

// File: rtl/dsm_noise_comb.sv
module dsm_noise_comb
  import dsm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   en,
  input  order_e order,
  input  logic   c1,
  input  logic   c2,
  input  logic   c3,
  output ofs_t   ofs_o
);
  logic p2_q, p3_q, pp3_q, debt_q;
  logic p2_d, p3_d, pp3_d, debt_d;
  logic over;
  int   raw;
  int   tot;

  // Correction from the carry pattern, then clamp with a held remainder.
  always_comb begin
    raw = int'(c1);
    if (order != ORD_FIRST) begin
      raw = raw + int'(c2) - int'(p2_q);
    end
    if (order == ORD_THIRD || order == ORD_THIRD_ALT) begin
      raw = raw + int'(c3) - 2 * int'(p3_q) + int'(pp3_q);
    end
    tot  = raw + int'(debt_q);
    over = (tot > OFS_MAX);
    if (over) begin
      ofs_o = ofs_t'(OFS_MAX);
    end else begin
      ofs_o = ofs_t'(tot);
    end
  end

  always_comb begin
    p2_d   = p2_q;
    p3_d   = p3_q;
    pp3_d  = pp3_q;
    debt_d = debt_q;
    if (clr) begin
      p2_d   = 1'b0;
      p3_d   = 1'b0;
      pp3_d  = 1'b0;
      debt_d = 1'b0;
    end else if (en) begin
      p2_d   = c2;
      p3_d   = c3;
      pp3_d  = p3_q;
      debt_d = over;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p2_q   <= 1'b0;
      p3_q   <= 1'b0;
      pp3_q  <= 1'b0;
      debt_q <= 1'b0;
    end else begin
      p2_q   <= p2_d;
      p3_q   <= p3_d;
      pp3_q  <= pp3_d;
      debt_q <= debt_d;
    end
  end

  // R3: the combined correction never drops below the window
  a_r3_low_bound: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (tot >= -OFS_MAX));

  // R10: a held remainder is never followed by a second overflow
  a_r10_single_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (en && debt_q) |-> (tot <= OFS_MAX));

endmodule

// File: rtl/dsm_divmod.sv
module dsm_divmod
  import dsm_pkg::*;
#(
  parameter int FW = 24,
  parameter int IW = 8,
  parameter int LW = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_clr,
  input  logic [IW-1:0]     int_set,
  input  logic [FW-1:0]     frac_set,
  input  logic [1:0]        order_sel,
  input  logic              dither_en,
  output logic [IW-1:0]     div_val,
  output logic signed [2:0] div_ofs,
  output logic              div_vld
);
  localparam int EXT = IW - 3;

  logic          en;
  logic          lfsr_bit;
  logic          dith_bit;
  logic [FW-1:0] resid [STAGES];
  logic [STAGES-1:0] carry;
  ofs_t          ofs_next;
  order_e        order;

  logic [IW-1:0] div_d;
  ofs_t          ofs_d;
  logic          vld_d;

  assign en       = ~sync_clr;
  assign order    = order_e'(order_sel);
  assign dith_bit = dither_en & lfsr_bit;

  dsm_lfsr #(.W(LW)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (sync_clr),
    .en    (en),
    .bit_o (lfsr_bit)
  );

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_head
      dsm_acc_stage #(.FW(FW)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sync_clr),
        .en      (en),
        .addend  (frac_set),
        .cin     (dith_bit),
        .resid_o (resid[k]),
        .carry_o (carry[k])
      );
    end else begin : g_tail
      dsm_acc_stage #(.FW(FW)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sync_clr),
        .en      (en),
        .addend  (resid[k-1]),
        .cin     (1'b0),
        .resid_o (resid[k]),
        .carry_o (carry[k])
      );
    end
  end

  dsm_noise_comb u_comb (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (sync_clr),
    .en    (en),
    .order (order),
    .c1    (carry[0]),
    .c2    (carry[1]),
    .c3    (carry[2]),
    .ofs_o (ofs_next)
  );

  always_comb begin
    div_d = '0;
    ofs_d = '0;
    vld_d = 1'b0;
    if (en) begin
      div_d = int_set + {{EXT{ofs_next[2]}}, ofs_next};
      ofs_d = ofs_next;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_val <= '0;
      div_ofs <= '0;
      div_vld <= 1'b0;
    end else begin
      div_val <= div_d;
      div_ofs <= ofs_d;
      div_vld <= vld_d;
    end
  end

  // R1: a clear empties the output
  a_r1_clear_out: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> (!div_vld && div_val == '0 && div_ofs == '0));

  // R2: every active edge yields a valid word
  a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_clr |=> div_vld);

  // R3: correction stays inside -3..+3
  a_r3_ofs_window: assert property (@(posedge clk) disable iff (!rst_n)
    div_vld |-> (div_ofs != 3'sb100));

  // R3: output word carries the integer sampled at its own edge
  a_r3_int_track: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_clr |=> ((div_val - {{EXT{div_ofs[2]}}, div_ofs}) == $past(int_set)));

endmodule

// File: tb/dsm_divmod_tb_top.sv
`timescale 1ns/1ps
module dsm_divmod_tb_top;
  localparam int FW = 24;
  localparam int IW = 8;
  localparam int LW = 23;
  localparam longint MOD = 64'd1 << FW;

  logic              clk;
  logic              rst_n;
  logic              sync_clr;
  logic [IW-1:0]     int_set;
  logic [FW-1:0]     frac_set;
  logic [1:0]        order_sel;
  logic              dither_en;
  logic [IW-1:0]     div_val;
  logic signed [2:0] div_ofs;
  logic              div_vld;

  int checks = 0;
  int fails  = 0;
  bit mon_on = 0;
  bit done   = 0;

  dsm_divmod #(.FW(FW), .IW(IW), .LW(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .int_set(int_set),
    .frac_set(frac_set), .order_sel(order_sel), .dither_en(dither_en),
    .div_val(div_val), .div_ofs(div_ofs), .div_vld(div_vld)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  longint m_a1, m_a2, m_a3;
  int     m_p2, m_p3, m_pp3, m_debt;
  logic [LW-1:0] m_lfsr;
  int     m_div, m_ofs;
  bit     m_vld;
  bit     m_clampy;
  int     clamp_seen = 0;

  always @(posedge clk) begin
    if (!rst_n || sync_clr) begin
      m_a1 = 0; m_a2 = 0; m_a3 = 0;
      m_p2 = 0; m_p3 = 0; m_pp3 = 0; m_debt = 0;
      m_lfsr = {1'b1, {(LW-2){1'b0}}, 1'b1};
      m_div = 0; m_ofs = 0; m_vld = 0; m_clampy = 0;
    end else begin
      longint s;
      int d, c1, c2, c3, y, t;
      d  = dither_en ? int'(m_lfsr[0]) : 0;
      s  = m_a1 + longint'(frac_set) + d;
      c1 = (s >= MOD) ? 1 : 0;  m_a1 = s % MOD;
      s  = m_a2 + m_a1;
      c2 = (s >= MOD) ? 1 : 0;  m_a2 = s % MOD;
      s  = m_a3 + m_a2;
      c3 = (s >= MOD) ? 1 : 0;  m_a3 = s % MOD;
      y = c1;
      if (order_sel != 2'd1) y = y + c2 - m_p2;
      if (order_sel == 2'd0 || order_sel == 2'd3) y = y + c3 - 2 * m_p3 + m_pp3;
      t = y + m_debt;
      m_clampy = (t > 3) || (m_debt != 0);
      if (t > 3) begin
        m_ofs = 3; m_debt = t - 3; clamp_seen++;
      end else begin
        m_ofs = t; m_debt = 0;
      end
      m_pp3 = m_p3; m_p3 = c3; m_p2 = c2;
      m_lfsr = {m_lfsr[LW-2:0], m_lfsr[LW-1] ^ m_lfsr[17]};
      m_div = (int'(int_set) + m_ofs) & ((1 << IW) - 1);
      m_vld = 1;
    end
  end

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      string tag;
      tag = m_clampy ? "R10" : "R9";
      chk(div_vld == m_vld, tag, int'(div_vld), int'(m_vld));
      chk(int'(div_val) == m_div, tag, int'(div_val), m_div);
      chk(int'(div_ofs) == m_ofs, tag, int'(div_ofs), m_ofs);
      if (div_vld) chk(int'(div_ofs) >= -3 && int'(div_ofs) <= 3, "R3", int'(div_ofs), 0);
    end
  end

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // clear for one cycle while the new settings are presented
  task automatic clear_to(input int iv, input int fv, input int ov, input bit dv);
    @(negedge clk);
    sync_clr  = 1'b1;
    int_set   = IW'(iv);
    frac_set  = FW'(fv);
    order_sel = 2'(ov);
    dither_en = dv;
    @(negedge clk);
    chk(!div_vld && div_val == 0 && div_ofs == 0, "R1", int'(div_val), 0);
    sync_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int sum, run, maxrun, prev;
    bit pend;
    rst_n = 1'b0; sync_clr = 1'b0; int_set = 8'd11; frac_set = '0;
    order_sel = 2'd3; dither_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(!div_vld, "R1", int'(div_vld), 0);
    chk(div_val == 0 && div_ofs == 0, "R1", int'(div_val), 0);
    rst_n  = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    chk(div_vld == 1'b1, "R2", int'(div_vld), 1);

    // R6: zero fraction gives the bare integer
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(div_val == 8'd11, "R6", int'(div_val), 11);
    end

    // R5: first order, one half
    clear_to(11, 1 << (FW - 1), 1, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(int'(div_val) == 11 + (i % 2), "R5", int'(div_val), 11 + (i % 2));
    end

    // R8: dither changes the second output
    clear_to(11, (1 << (FW - 1)) - 1, 1, 0);
    repeat (2) @(negedge clk);
    chk(div_val == 8'd11, "R8", int'(div_val), 11);
    clear_to(11, (1 << (FW - 1)) - 1, 1, 1);
    repeat (2) @(negedge clk);
    chk(div_val == 8'd12, "R8", int'(div_val), 12);

    // R4: exact mean in third and second order
    for (int o = 2; o <= 3; o++) begin
      clear_to(11, 24'h555555, o, 0);
      sum = 0;
      for (int i = 0; i < 4096; i++) begin
        @(negedge clk);
        sum += int'(div_ofs);
      end
      chk(sum >= 1365 - 3 && sum <= 1365 + 3, "R4", sum, 1365);
    end

    // R7: fraction near 0.01 keeps the divider busy
    clear_to(11, 167772, 3, 1);
    repeat (256) @(negedge clk);
    prev = int'(div_val); run = 1; maxrun = 1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (int'(div_val) == prev) run++; else run = 1;
      if (run > maxrun) maxrun = run;
      prev = int'(div_val);
    end
    chk(maxrun <= 32, "R7", maxrun, 32);

    // R9 / R10: setting changes landing on clamp and payback cycles
    clear_to(40, 24'h3A5C1F, 3, 1);
    pend = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (pend) begin
        chk(((int'(div_val) - int'(div_ofs)) & 255) == int'(int_set), "R9",
            int'(div_val) - int'(div_ofs), int'(int_set));
        pend = 0;
      end
      if (i % 37 == 36) begin
        int_set = (int_set == 8'd40) ? 8'd100 : 8'd40;
        pend = 1;
      end
      if (i % 501 == 500) frac_set = frac_set + 24'h13579B;
    end
    chk(clamp_seen > 0, "R10", clamp_seen, 1);

    @(negedge clk);
    mon_on = 1'b0;
    done   = 1'b1;
    summary();
    $finish;
  end

endmodule